// File: doc/BRIEF.md
# Commutative Floating-Point Minimum and Maximum Unit

This unit picks the smaller or the larger of two single-precision (binary32) values and returns the answer one clock after the request. Each request carries two control bits. One bit chooses minimum or maximum. The other chooses how NaNs are handled. Because the handling is chosen per request, two neighbouring operations can use different NaN rules without any mode register in between.

Under NaN-favouring handling, any NaN input poisons the result. Under number-favouring handling, a single NaN is dropped and the numeric operand wins. When both inputs are NaN, the two payloads are merged so that the result does not depend on operand order. The default merge is a bitwise OR, which lets each payload bit stand for one error source. A parameter changes the merge to keep the larger payload instead.

Ordinary values are ordered by their sign-magnitude bit patterns, so no subtractor is needed. Under this ordering -0 sorts below +0.

Top module: `fp_minmax`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, before any request, `out_valid`, `invalid` and `result` are all 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `invalid` change only after a cycle with `in_valid` high; otherwise they hold.
- R3: When neither operand is NaN, `result` is the smaller operand (`sel_max`=0) or the larger operand (`sel_max`=1), bit for bit, whatever the value of `num_mode`. Infinities are the extremes of the ordering, and -0 (0x80000000) counts as less than +0 (0x00000000).
- R4: With `num_mode`=0 and exactly one NaN operand, `result` is that NaN with bit 22 forced to 1, its sign and bits 21:0 unchanged. A NaN is exponent bits 30:23 all ones with bits 22:0 nonzero.
- R5: With `num_mode`=1 and exactly one NaN operand, `result` is the other operand unchanged.
- R6: When both operands are NaN, in either mode, `result` has bits 30:22 all ones. Its sign is the OR of the two signs, and bits 21:0 are the OR of the two payloads (with the default `MERGE_MAX`=0).
- R7: `invalid` is 1 exactly when the request had at least one signalling NaN: a NaN with bit 22 clear.
- R8: Swapping `op_a` and `op_b` gives an identical `result` and `invalid` for every input and every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| sel_max | input | 1 | 0 selects minimum, 1 selects maximum |
| num_mode | input | 1 | 0 selects NaN-favouring handling, 1 selects number-favouring handling |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Selected or merged value |
| invalid | output | 1 | A signalling NaN was seen in the request |

## Verification
The checker watches four properties on every cycle: the one-cycle strobe timing, the result holding between requests, the invalid flag tracking signalling inputs, and two NaN facts. Every NaN result must be quiet. A NaN-favouring request that has a NaN input must yield a NaN, and a request with no NaN input must return one of its own operands. Only the bench scenarios can show which operand was chosen and the exact merged bit pattern. They also show that swapping the operands changes nothing, because each vector runs in both orders and both runs are compared against one expected value.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int W      = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int QBIT   = FRAC_W - 1;
  localparam int PAY_W  = FRAC_W - 1;

  function automatic logic exp_ones(input logic [W-1:0] x);
    return &x[W-2 -: EXP_W];
  endfunction

  // ordering key: unsigned compare of keys equals sign-magnitude order, -0 < +0
  function automatic logic [W-1:0] order_key(input logic [W-1:0] x);
    return x[W-1] ? ~x : {1'b1, x[W-2:0]};
  endfunction

  function automatic logic [PAY_W-1:0] merge_pay(input logic [PAY_W-1:0] p,
                                                 input logic [PAY_W-1:0] q,
                                                 input logic take_max);
    if (take_max) return (p > q) ? p : q;
    return p | q;
  endfunction
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  logic [W-1:0] x,
  output logic         is_nan,
  output logic         is_snan,
  output logic [W-1:0] quiet_x
);
  always_comb begin
    is_nan  = exp_ones(x) && (x[FRAC_W-1:0] != '0);
    is_snan = is_nan && !x[QBIT];
    quiet_x = x;
    quiet_x[QBIT] = 1'b1;
  end
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
  import fpmm_pkg::*;
(
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel_max,
  output logic [W-1:0] pick
);
  logic a_below_b;
  always_comb begin
    a_below_b = order_key(a) < order_key(b);
    if (sel_max) pick = a_below_b ? b : a;
    else         pick = a_below_b ? a : b;
  end
endmodule

// File: rtl/fpmm_nan_merge.sv
module fpmm_nan_merge
  import fpmm_pkg::*;
#(
  parameter bit MERGE_MAX = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] merged
);
  always_comb begin
    merged[W-1]           = a[W-1] | b[W-1];
    merged[W-2 -: EXP_W]  = '1;
    merged[QBIT]          = 1'b1;
    merged[PAY_W-1:0]     = merge_pay(a[PAY_W-1:0], b[PAY_W-1:0], MERGE_MAX);
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax
  import fpmm_pkg::*;
#(
  parameter bit MERGE_MAX = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          sel_max,
  input  logic          num_mode,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic          invalid
);
  localparam int NOPS = 2;

  logic [W-1:0] ops     [NOPS];
  logic [W-1:0] quiet   [NOPS];
  logic         nan_v   [NOPS];
  logic         snan_v  [NOPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fpmm_classify u_cls (
      .x       (ops[i]),
      .is_nan  (nan_v[i]),
      .is_snan (snan_v[i]),
      .quiet_x (quiet[i])
    );
  end

  logic [W-1:0] numeric_pick, nan_merged, next_result;
  logic         any_snan;

  fpmm_order u_order (
    .a       (op_a),
    .b       (op_b),
    .sel_max (sel_max),
    .pick    (numeric_pick)
  );

  fpmm_nan_merge #(.MERGE_MAX(MERGE_MAX)) u_merge (
    .a      (op_a),
    .b      (op_b),
    .merged (nan_merged)
  );

  always_comb begin
    any_snan = snan_v[0] | snan_v[1];
    unique case ({nan_v[0], nan_v[1]})
      2'b11:   next_result = nan_merged;
      2'b10:   next_result = num_mode ? op_b : quiet[0];
      2'b01:   next_result = num_mode ? op_a : quiet[1];
      default: next_result = numeric_pick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= next_result;
        invalid <= any_snan;
      end
    end
  end
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk
  import fpmm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          sel_max,
  input logic          num_mode,
  input logic          out_valid,
  input logic [W-1:0]  result,
  input logic          invalid
);
  wire a_nan  = exp_ones(op_a) && (op_a[FRAC_W-1:0] != '0);
  wire b_nan  = exp_ones(op_b) && (op_b[FRAC_W-1:0] != '0);
  wire a_snan = a_nan && !op_a[QBIT];
  wire b_snan = b_nan && !op_b[QBIT];
  wire r_nan  = exp_ones(result) && (result[FRAC_W-1:0] != '0);

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(invalid)));
  // R7
  invalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (a_snan || b_snan)) |=> invalid);
  // R7
  invalid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_snan && !b_snan) |=> !invalid);
  // R4
  nan_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !num_mode && (a_nan || b_nan)) |=> r_nan);
  // R6
  nan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && r_nan) |-> result[QBIT]);
  // R3
  pick_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !a_nan && !b_nan) |=> (result == $past(op_a) || result == $past(op_b)));
endmodule

bind fp_minmax fp_minmax_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .sel_max   (sel_max),
  .num_mode  (num_mode),
  .out_valid (out_valid),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/fp_minmax_bench.sv
module fp_minmax_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sel_max = 1'b0, num_mode = 1'b0;
  logic        out_valid, invalid;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp_minmax u_fp_minmax (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sel_max(sel_max), .num_mode(num_mode), .out_valid(out_valid),
    .result(result), .invalid(invalid)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        mx;
    logic        nm;
    logic [31:0] exp;
    logic        inv;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h40000000, 1'b0, 1'b0, 32'h3F800000, 1'b0}, // R3 min 1,2
    '{32'h3F800000, 32'h40000000, 1'b1, 1'b0, 32'h40000000, 1'b0}, // R3 max 1,2
    '{32'hBF800000, 32'hC0000000, 1'b0, 1'b0, 32'hC0000000, 1'b0}, // R3 min -1,-2
    '{32'hBF800000, 32'hC0000000, 1'b1, 1'b1, 32'hBF800000, 1'b0}, // R3 max -1,-2
    '{32'h00000000, 32'h80000000, 1'b0, 1'b0, 32'h80000000, 1'b0}, // R3 min zeros
    '{32'h80000000, 32'h00000000, 1'b1, 1'b1, 32'h00000000, 1'b0}, // R3 max zeros
    '{32'hFF800000, 32'h3F800000, 1'b0, 1'b1, 32'hFF800000, 1'b0}, // R3 -inf
    '{32'h7F800000, 32'hC0000000, 1'b1, 1'b0, 32'h7F800000, 1'b0}, // R3 +inf
    '{32'h3FC00000, 32'h3FA00000, 1'b0, 1'b0, 32'h3FA00000, 1'b0}, // R3 close values
    '{32'h3F800000, 32'h7FC00005, 1'b0, 1'b0, 32'h7FC00005, 1'b0}, // R4 qnan
    '{32'h7FC00005, 32'h3F800000, 1'b1, 1'b0, 32'h7FC00005, 1'b0}, // R4 qnan max
    '{32'h3F800000, 32'h7F800003, 1'b0, 1'b0, 32'h7FC00003, 1'b1}, // R4 R7 snan
    '{32'h3F800000, 32'h7FC00005, 1'b0, 1'b1, 32'h3F800000, 1'b0}, // R5
    '{32'h7F800003, 32'hC0000000, 1'b1, 1'b1, 32'hC0000000, 1'b1}, // R5 R7
    '{32'h7FC00005, 32'hFFC00010, 1'b0, 1'b0, 32'hFFC00015, 1'b0}, // R6
    '{32'hFFC00010, 32'h7FC00005, 1'b1, 1'b1, 32'hFFC00015, 1'b0}, // R6 num mode
    '{32'h7F800003, 32'h7FC00005, 1'b0, 1'b0, 32'h7FC00007, 1'b1}  // R6 R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic mx, input logic nm);
    op_a = a; op_b = b; sel_max = mx; num_mode = nm; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
    check("R1 result in reset", result, 32'h0);
    check("R1 invalid in reset", {31'b0, invalid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after release", {31'b0, out_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].a, VECS[i].b, VECS[i].mx, VECS[i].nm);
      check("R2 out_valid", {31'b0, out_valid}, 32'h1);
      check($sformatf("R3-R6 vec %0d result", i), result, VECS[i].exp);
      check($sformatf("R7 vec %0d invalid", i), {31'b0, invalid}, {31'b0, VECS[i].inv});
      issue(VECS[i].b, VECS[i].a, VECS[i].mx, VECS[i].nm);
      check($sformatf("R8 vec %0d swapped result", i), result, VECS[i].exp);
      check($sformatf("R8 vec %0d swapped invalid", i), {31'b0, invalid}, {31'b0, VECS[i].inv});
    end

    // R2: idle cycles hold result and drop out_valid
    issue(32'h7F800001, 32'h3F800000, 1'b0, 1'b0);
    check("R7 snan invalid", {31'b0, invalid}, 32'h1);
    check("R4 snan quieted", result, 32'h7FC00001);
    op_a = 32'h40000000; op_b = 32'h3F800000; sel_max = 1'b1; num_mode = 1'b1;
    @(negedge clk);
    check("R2 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R2 idle result hold", result, 32'h7FC00001);
    check("R2 idle invalid hold", {31'b0, invalid}, 32'h1);
    @(negedge clk);
    check("R2 second idle hold", result, 32'h7FC00001);

    // R2 back-to-back requests
    op_a = 32'h3F800000; op_b = 32'h40000000; sel_max = 1'b0; num_mode = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    check("R2 b2b first", result, 32'h3F800000);
    sel_max = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", result, 32'h40000000);
    check("R2 b2b valid", {31'b0, out_valid}, 32'h1);
    @(negedge clk);
    check("R2 b2b valid drop", {31'b0, out_valid}, 32'h0);

    // R1 reset again clears state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears result", result, 32'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule